// File: doc/BRIEF.md
# Bit-Sliced 32-Bit Integer ALU

This block is a purely combinational integer arithmetic logic unit for a 32-bit datapath. It takes two operands and a 3-bit operation code. It returns a result word and three flags: zero, carry-out and signed overflow. The datapath is one 1-bit cell repeated once per bit. Each cell holds an AND gate, an OR gate and a full adder, and a per-cell multiplexer picks which of them drives the cell's result bit. Carries ripple from the least significant cell to the most significant one.

Subtraction runs through the same adders. The top bit of the operation code inverts every bit of the second operand and also forces a carry of 1 into the lowest cell, which gives `a + ~b + 1`. Signed less-than comparison is taken from that subtraction. The most significant cell's sum, corrected by signed overflow, is routed back into bit 0 of the result. Equality is tested by subtracting and reading the zero flag.

Top module: `alu_bitslice32`

## Requirements
- R1: Operation code 3'b000 drives `result` with the bitwise AND of `opnd_a` and `opnd_b`.
- R2: Operation code 3'b001 drives `result` with the bitwise OR of `opnd_a` and `opnd_b`.
- R3: Operation code 3'b010 drives `result` with `opnd_a + opnd_b` modulo 2^32, and `carry_out` with the unsigned carry out of bit 31.
- R4: Operation code 3'b110 drives `result` with `opnd_a - opnd_b` modulo 2^32, formed as `opnd_a + ~opnd_b + 1`. `carry_out` is the carry out of bit 31 of that sum, so it is 1 exactly when `opnd_a >= opnd_b` as unsigned values.
- R5: Operation code 3'b111 drives `result[0]` with 1 when `opnd_a < opnd_b` as signed two's-complement values and 0 otherwise. `result[31:1]` are 0. The comparison stays correct when `opnd_a - opnd_b` overflows.
- R6: `zero` is 1 exactly when all 32 bits of `result` are 0, for every operation code.
- R7: `overflow` is 1 under 3'b010 and 3'b110 exactly when the signed two's-complement result cannot be represented in 32 bits. Under 3'b000, 3'b001 and 3'b111, both `overflow` and `carry_out` are 0.
- R8: The unused codes 3'b011, 3'b100 and 3'b101 give `result` = 0, `carry_out` = 0 and `overflow` = 0, and therefore `zero` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | input | 3 | Operation select (encodings in R1 to R5 and R8) |
| result | output | 32 | Result word |
| zero | output | 1 | High when `result` is all zeros |
| carry_out | output | 1 | Carry out of the top cell for add and subtract, else 0 |
| overflow | output | 1 | Signed overflow for add and subtract, else 0 |

## Verification
The bench builds the block with its default width of 32 bits only. At that width the edge operands 0, 1, all-ones, 0x7FFFFFFF and 0x80000000 exercise the exact carry and overflow boundaries of the top cell. The bench crosses those five values with each other under all eight operation codes, including the three unused ones. This reaches the less-than case where the subtraction overflows and the case where subtracting equal values sets the zero flag. A hand-computed vector table and a large batch of random operands, both checked against a behavioural model, cover the rest.

// File: rtl/alu_pkg.sv
// Package: shared types for the bit-sliced ALU.
// Assumes: operation codes are 3 bits wide and fixed; the top bit marks
// the subtracting operations (subtract and less-than).
package alu_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    // Source of each cell's result bit
    typedef enum logic [2:0] {
        SEL_AND  = 3'd0,
        SEL_OR   = 3'd1,
        SEL_SUM  = 3'd2,
        SEL_LESS = 3'd3,
        SEL_ZERO = 3'd4
    } cell_sel_e;

endpackage

// File: rtl/alu_ctrl.sv
// Module: alu_ctrl
// Decodes the 3-bit operation code into the controls shared by every cell.
// Assumes: codes outside the five defined ones select a forced-zero result.
// The top code bit drives both operand-B inversion and the lowest carry-in.
module alu_ctrl
    import alu_pkg::*;
(
    input  logic [2:0] op_code,
    output logic       b_invert,
    output logic       carry_seed,
    output cell_sel_e  cell_sel,
    output logic       arith_op
);

    // Invert and carry seed come straight from the top code bit
    always_comb begin
        b_invert   = op_code[2];
        carry_seed = op_code[2];
    end

    // Pick the cell output source and mark add/subtract for the flags
    always_comb begin
        cell_sel = SEL_ZERO;
        arith_op = 1'b0;
        case (op_code)
            OP_AND: cell_sel = SEL_AND;
            OP_OR:  cell_sel = SEL_OR;
            OP_ADD: begin
                cell_sel = SEL_SUM;
                arith_op = 1'b1;
            end
            OP_SUB: begin
                cell_sel = SEL_SUM;
                arith_op = 1'b1;
            end
            OP_SLT: cell_sel = SEL_LESS;
            default: begin
                cell_sel = SEL_ZERO;
                arith_op = 1'b0;
            end
        endcase
    end

    // R8: an unused code never drives the adder result or the flags
    always_comb begin
        if (!(op_code inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT})) begin
            p_unused_sel_r8: assert (cell_sel == SEL_ZERO && !arith_op)
                else $error("unused code did not select zero");
        end
    end

endmodule

// File: rtl/alu_cell.sv
// Module: alu_cell
// One bit of the ALU: AND, OR and a full adder, with a multiplexer that
// picks the bit's result. The second operand is optionally inverted first.
// Assumes: 'less' is only non-zero on the lowest cell.
module alu_cell
    import alu_pkg::*;
(
    input  logic      a,
    input  logic      b,
    input  logic      b_invert,
    input  logic      carry_in,
    input  logic      less,
    input  cell_sel_e sel,
    output logic      res,
    output logic      sum,
    output logic      carry_out
);

    logic b_eff;

    // Full adder on a and the possibly inverted b
    always_comb begin
        b_eff     = b ^ b_invert;
        sum       = a ^ b_eff ^ carry_in;
        carry_out = (a & b_eff) | (a & carry_in) | (b_eff & carry_in);
    end

    // Output multiplexer
    always_comb begin
        case (sel)
            SEL_AND:  res = a & b;
            SEL_OR:   res = a | b;
            SEL_SUM:  res = sum;
            SEL_LESS: res = less;
            default:  res = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_flags.sv
// Module: alu_flags
// Derives the zero, carry-out and overflow flags, and the less-than bit
// that is fed back into bit 0 of the result.
// Assumes: carry inputs are those into and out of the most significant cell.
module alu_flags #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] result,
    input  logic             msb_sum,
    input  logic             msb_carry_in,
    input  logic             msb_carry_out,
    input  logic             arith_op,
    output logic             set_less,
    output logic             zero,
    output logic             carry_out,
    output logic             overflow
);

    logic ovf_raw;

    // Signed overflow of the adder and the overflow-corrected sign
    always_comb begin
        ovf_raw  = msb_carry_in ^ msb_carry_out;
        set_less = msb_sum ^ ovf_raw;
    end

    // Flags reported at the ports
    always_comb begin
        zero      = ~|result;
        carry_out = arith_op & msb_carry_out;
        overflow  = arith_op & ovf_raw;
    end

    // R6: zero flag agrees with the population of the result
    always_comb begin
        p_zero_count_r6: assert (zero == ($countones(result) == 0))
            else $error("zero flag disagrees with result");
    end

endmodule

// File: rtl/alu_bitslice32.sv
// Module: alu_bitslice32
// Combinational ALU built from WIDTH identical one-bit cells with a ripple
// carry. Supports AND, OR, add, subtract and signed set-on-less-than.
// Assumes: WIDTH >= 2; no clock or reset (pure combinational path).
module alu_bitslice32
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry_out,
    output logic             overflow
);

    localparam int MSB = WIDTH - 1;

    logic             b_invert;
    logic             carry_seed;
    logic             arith_op;
    cell_sel_e        cell_sel;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] sum_bits;
    logic             set_less;

    alu_ctrl u_ctrl (
        .op_code    (op_code),
        .b_invert   (b_invert),
        .carry_seed (carry_seed),
        .cell_sel   (cell_sel),
        .arith_op   (arith_op)
    );

    assign carry[0] = carry_seed;

    // Replicate one cell per bit; only cell 0 receives the less-than bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic less_in;
        if (i == 0) begin : g_lsb
            assign less_in = set_less;
        end else begin : g_upper
            assign less_in = 1'b0;
        end
        alu_cell u_cell (
            .a         (opnd_a[i]),
            .b         (opnd_b[i]),
            .b_invert  (b_invert),
            .carry_in  (carry[i]),
            .less      (less_in),
            .sel       (cell_sel),
            .res       (result[i]),
            .sum       (sum_bits[i]),
            .carry_out (carry[i+1])
        );
    end

    alu_flags #(.WIDTH(WIDTH)) u_flags (
        .result        (result),
        .msb_sum       (sum_bits[MSB]),
        .msb_carry_in  (carry[MSB]),
        .msb_carry_out (carry[WIDTH]),
        .arith_op      (arith_op),
        .set_less      (set_less),
        .zero          (zero),
        .carry_out     (carry_out),
        .overflow      (overflow)
    );

    // R3/R4: the rippled adder equals the behavioural sum or difference
    always_comb begin
        if (op_code == OP_ADD) begin
            p_add_value_r3: assert (result == WIDTH'(opnd_a + opnd_b) && result == sum_bits)
                else $error("add result mismatch");
        end
        if (op_code == OP_SUB) begin
            p_sub_value_r4: assert (result == WIDTH'(opnd_a - opnd_b))
                else $error("subtract result mismatch");
        end
    end

    // R5: less-than only ever sets bit 0, and matches a signed compare
    always_comb begin
        if (op_code == OP_SLT) begin
            p_slt_upper_r5: assert (result[MSB:1] == '0 &&
                                    result[0] == ($signed(opnd_a) < $signed(opnd_b)))
                else $error("less-than result mismatch");
        end
    end

    // R7: add overflow follows operand and result signs; no flags on logic ops
    always_comb begin
        if (op_code == OP_ADD) begin
            p_add_overflow_r7: assert (overflow ==
                ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])))
                else $error("add overflow mismatch");
        end
        if (op_code inside {OP_AND, OP_OR, OP_SLT}) begin
            p_no_overflow_r7: assert (!overflow && !carry_out)
                else $error("flag raised on non-arithmetic code");
        end
    end

    // R8: unused codes leave everything cleared
    always_comb begin
        if (op_code inside {3'b011, 3'b100, 3'b101}) begin
            p_unused_out_r8: assert (result == '0 && zero && !carry_out && !overflow)
                else $error("unused code produced output");
        end
    end

endmodule

// File: tb/sim_alu_bitslice32.sv
// Bench for alu_bitslice32: table of hand-computed vectors, then edge-value
// sweep and random operands checked against a behavioural model.
module sim_alu_bitslice32;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic [W-1:0] opnd_a;
    logic [W-1:0] opnd_b;
    logic [2:0]   op_code;
    logic [W-1:0] result;
    logic         zero;
    logic         carry_out;
    logic         overflow;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // 200 MHz clock
    always #2.5 clk = ~clk;

    alu_bitslice32 #(.WIDTH(W)) u0 (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_code   (op_code),
        .result    (result),
        .zero      (zero),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    // Vector: {op, a, b, result, zero, carry, overflow}
    localparam int NV = 14;
    localparam logic [101:0] VEC [NV] = '{
        {3'b000, 32'hFFFF0000, 32'h0FF00FF0, 32'h0FF00000, 1'b0, 1'b0, 1'b0}, // R1
        {3'b001, 32'h12340000, 32'h00005678, 32'h12345678, 1'b0, 1'b0, 1'b0}, // R2
        {3'b010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0, 1'b1}, // R3 R7
        {3'b010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b1, 1'b0}, // R3 R6
        {3'b110, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b1, 1'b0}, // R4 R6
        {3'b110, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0}, // R4
        {3'b110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b1}, // R4 R7
        {3'b111, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 1'b0}, // R5 overflowing
        {3'b111, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R5
        {3'b111, 32'h00000002, 32'h00000003, 32'h00000001, 1'b0, 1'b0, 1'b0}, // R5
        {3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R8
        {3'b100, 32'h80000000, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R8
        {3'b101, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R8
        {3'b000, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b0}  // R6 idle
    };

    localparam logic [W-1:0] EDGE [5] = '{32'h0, 32'h1, 32'hFFFFFFFF,
                                          32'h7FFFFFFF, 32'h80000000};

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R8";
        endcase
    endfunction

    // Behavioural model: returns {result, carry, overflow}
    function automatic logic [W+1:0] model(input logic [2:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic [W:0]   s;
        logic [W-1:0] r = '0;
        logic         c = 1'b0;
        logic         v = 1'b0;
        case (op)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010: begin
                s = {1'b0, a} + {1'b0, b};
                r = s[W-1:0];
                c = s[W];
                v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            end
            3'b110: begin
                s = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
                r = s[W-1:0];
                c = s[W];
                v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
            end
            3'b111: r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: r = '0;
        endcase
        return {r, c, v};
    endfunction

    task automatic apply_check(input logic [2:0] op, input logic [W-1:0] a,
                               input logic [W-1:0] b, input logic [W-1:0] er,
                               input logic ez, input logic ec, input logic ev);
        @(posedge clk);
        op_code = op;
        opnd_a  = a;
        opnd_b  = b;
        @(negedge clk);
        checks++;
        if (result !== er || zero !== ez || carry_out !== ec || overflow !== ev) begin
            fails++;
            $display("FAIL %s%s op=%b a=%h b=%h got res=%h z=%b c=%b v=%b exp res=%h z=%b c=%b v=%b",
                     tag_of(op), (zero !== ez) ? "/R6" : ((overflow !== ev) ? "/R7" : ""),
                     op, a, b, result, zero, carry_out, overflow, er, ez, ec, ev);
        end
    endtask

    task automatic model_check(input logic [2:0] op, input logic [W-1:0] a,
                               input logic [W-1:0] b);
        logic [W+1:0] m = model(op, a, b);
        apply_check(op, a, b, m[W+1:2], (m[W+1:2] == '0), m[1], m[0]);
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000 && !done) begin
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        op_code = 3'b000;
        opnd_a  = '0;
        opnd_b  = '0;
        // Idle state: all-zero inputs give zero result with zero flag (R6)
        @(negedge clk);
        checks++;
        if (result !== '0 || zero !== 1'b1 || carry_out !== 1'b0 || overflow !== 1'b0) begin
            fails++;
            $display("FAIL R6 idle got res=%h z=%b exp res=0 z=1", result, zero);
        end
        // Hand-computed table
        for (int i = 0; i < NV; i++) begin
            apply_check(VEC[i][101:99], VEC[i][98:67], VEC[i][66:35],
                        VEC[i][34:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        // Edge sweep across every code, including unused ones (R1..R8)
        for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    model_check(3'(op), EDGE[i], EDGE[j]);
                end
            end
        end
        // Equal operands under subtract set zero (R4, R6)
        for (int i = 0; i < 5; i++) begin
            apply_check(3'b110, EDGE[i], EDGE[i], '0, 1'b1, 1'b1, 1'b0);
        end
        // Random operands on all codes
        for (int k = 0; k < 4000; k++) begin
            model_check(3'($urandom_range(0, 7)), W'($urandom), W'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule